// File: doc/BRIEF.md
# Branch Source Trace Queue

This block is a small debug trace buffer. Each time the core takes a branch while tracing is on, the block records the low address bits of the branch source instruction in a register chain of eight entries. A debugger reads the entries back through a register interface. The chain does not use read and write pointers. Every captured branch moves all stored entries down one place. The newest record goes into entry 0, which is the head, and the record in the last entry is discarded.

Every entry carries a valid flag. The flag is set when a record is captured. It is cleared when the debugger reads that entry, and it is cleared on every entry when tracing is switched on. A synchronous reset clears only the flags and leaves the stored address bits as they were. The debugger selects an entry with an index. The read word is formed from the selected entry with no register delay. A read strobe clears the flag of the selected entry and does not remove the entry from the chain.

Top module: `branch_trace_queue`

## Requirements
- R1: The queue holds DEPTH entries (default eight). A captured branch moves entry k to entry k+1 for every k, and the content of the last entry is dropped.
- R2: A captured branch loads entry 0 with flag 1 and with bits 27..0 of `br_src_addr`. The new content is visible on the clock edge at which `br_taken` is sampled high.
- R3: `rd_data` shows the entry chosen by `rd_idx` (0 is the newest) in the same cycle. Bit 31 is the valid flag, bits 30..28 are always 0, and bits 27..0 are the stored address bits.
- R4: A read strobe with no capture in that cycle clears the flag of the selected entry only. No entry moves, and every other flag and every address is unchanged.
- R5: When a capture and a read strobe occur in the same cycle, the capture wins and the read clear is dropped. The new head is valid.
- R6: When `trace_en` is high in a cycle and was low in the cycle before, every flag is cleared. A branch captured in that same cycle still enters entry 0 with flag 1, and the entries it pushes down are invalid.
- R7: While `trace_en` is low, `br_taken` is ignored and no entry moves.
- R8: A synchronous active-low reset clears every flag to 0. A high `trace_en` in the first cycle after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trace_en | input | 1 | Trace enable level |
| br_taken | input | 1 | Taken-branch strobe |
| br_src_addr | input | 32 | Source address of the taken branch |
| rd_stb | input | 1 | Read strobe for the selected entry |
| rd_idx | input | 3 | Entry select, 0 is the newest |
| rd_data | output | 32 | Read word of the selected entry |

## Verification
There is one register stage between any strobe and the state it changes. A capture, a read clear, an enable edge or a reset therefore shows up on `rd_data` one edge after the cycle in which it is sampled. The index select, by contrast, is combinational and has no delay. The bench drives each stimulus on the falling edge and lets exactly one rising edge pass. It then returns every strobe to idle and steps `rd_idx` through all entries, checking each word against a reference queue that it has already advanced by one step. Because the strobes are idle during this sweep, the edges that pass during it cannot change any state.

// File: rtl/bstq_pkg.sv
// Shared defaults and the per-cycle command type for the branch trace queue.
// Assumes: the consumers size their own arrays from these defaults.
package bstq_pkg;
    localparam int DEF_DEPTH  = 8;
    localparam int DEF_ADDR_W = 28;
    localparam int DEF_WORD_W = 32;

    // One cycle's decision, made by the control unit.
    typedef struct packed {
        logic shift;   // capture a branch and push every entry down
        logic wipe;    // trace enable just rose: drop all flags
    } bstq_cmd_t;
endpackage

// File: rtl/bstq_ctrl.sv
// Control unit. It detects the rising edge of the enable, decides whether a branch
// is captured, and builds a clear mask with one bit per entry.
// Assumes: rd_idx is below DEPTH. A capture overrides a read clear in the same cycle.
module bstq_ctrl #(
    parameter int DEPTH = bstq_pkg::DEF_DEPTH,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trace_en,
    input  logic                   br_taken,
    input  logic                   rd_stb,
    input  logic [IDX_W-1:0]       rd_idx,
    output bstq_pkg::bstq_cmd_t    cmd,
    output logic [DEPTH-1:0]       clr_vec
);
    logic en_q;

    // Remember last cycle's enable level so that its rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= trace_en;
    end

    // Decide capture, wipe and the per-entry clear mask for this cycle.
    always_comb begin
        cmd.wipe  = trace_en & ~en_q;
        cmd.shift = br_taken & trace_en;
        for (int i = 0; i < DEPTH; i++) begin
            clr_vec[i] = cmd.wipe | (rd_stb & ~cmd.shift & (rd_idx == IDX_W'(i)));
        end
    end
endmodule

// File: rtl/bstq_slot.sv
// One queue entry: a valid flag with reset and address bits without reset.
// Assumes: vld_d arrives already masked for a wipe. A shift overrides a clear.
module bstq_slot #(
    parameter int ADDR_W = bstq_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              clr,
    input  logic              vld_d,
    input  logic [ADDR_W-1:0] addr_d,
    output logic              vld_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Flag: reset to 0, loaded on a shift, otherwise cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= 1'b0;
        else if (shift) vld_q <= vld_d;
        else if (clr)   vld_q <= 1'b0;
    end

    // Address bits: no reset, loaded only on a shift.
    always_ff @(posedge clk) begin
        if (shift) addr_q <= addr_d;
    end

    a_r1_slot_load: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (vld_q == $past(vld_d)) && (addr_q == $past(addr_d)));

    a_r8_reset_flag: assert property (@(posedge clk)
        !rst_n |=> !vld_q);
endmodule

// File: rtl/bstq_readout.sv
// Read port: selects one entry and builds the read word as
// flag, reserved zero bits, address bits.
// Assumes: WORD_W >= ADDR_W + 1. The word is combinational from the entry registers.
module bstq_readout #(
    parameter int DEPTH  = bstq_pkg::DEF_DEPTH,
    parameter int ADDR_W = bstq_pkg::DEF_ADDR_W,
    parameter int WORD_W = bstq_pkg::DEF_WORD_W,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [WORD_W-1:0]            word
);
    localparam int RSV_W = WORD_W - 1 - ADDR_W;

    logic              sel_vld;
    logic [ADDR_W-1:0] sel_addr;

    // Pick the entry named by the index.
    always_comb begin
        sel_vld  = vld[rd_idx];
        sel_addr = addr[rd_idx];
    end

    // Form the word, with a reserved zero field when there is room for one.
    generate
        if (RSV_W > 0) begin : g_rsv
            assign word = {sel_vld, {RSV_W{1'b0}}, sel_addr};
        end else begin : g_norsv
            assign word = {sel_vld, sel_addr};
        end
    endgenerate
endmodule

// File: rtl/branch_trace_queue.sv
// Top of the branch source trace queue: control, DEPTH entry slots chained as a
// shift register, and the read port.
// Assumes: br_taken is a one-cycle strobe per taken branch. rd_idx < DEPTH.
module branch_trace_queue #(
    parameter int DEPTH  = bstq_pkg::DEF_DEPTH,
    parameter int ADDR_W = bstq_pkg::DEF_ADDR_W,
    parameter int WORD_W = bstq_pkg::DEF_WORD_W,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              br_taken,
    input  logic [WORD_W-1:0] br_src_addr,
    input  logic              rd_stb,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    bstq_pkg::bstq_cmd_t         cmd;
    logic [DEPTH-1:0]            clr_vec;
    logic [DEPTH-1:0]            vld;
    logic [DEPTH-1:0][ADDR_W-1:0] addr;
    logic [DEPTH-1:0]            d_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] d_addr;
    logic                        unused_hi;

    assign unused_hi = ^br_src_addr[WORD_W-1:ADDR_W];

    bstq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .br_taken(br_taken),
        .rd_stb(rd_stb), .rd_idx(rd_idx), .cmd(cmd), .clr_vec(clr_vec)
    );

    // Chain the slots: the head takes the new branch, and every other slot takes its
    // neighbour, which loses its flag if the enable has just risen.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            if (g == 0) begin : g_head
                assign d_vld[g]  = 1'b1;
                assign d_addr[g] = br_src_addr[ADDR_W-1:0];
            end else begin : g_body
                assign d_vld[g]  = vld[g-1] & ~cmd.wipe;
                assign d_addr[g] = addr[g-1];
            end
            bstq_slot #(.ADDR_W(ADDR_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .shift(cmd.shift), .clr(clr_vec[g]),
                .vld_d(d_vld[g]), .addr_d(d_addr[g]),
                .vld_q(vld[g]), .addr_q(addr[g])
            );
        end
    endgenerate

    bstq_readout #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_rd (
        .vld(vld), .addr(addr), .rd_idx(rd_idx), .word(rd_data)
    );

    a_r2_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && trace_en) |=> vld[0] && (addr[0] == $past(br_src_addr[ADDR_W-1:0])));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !br_taken) |=> !vld[$past(rd_idx)] && $stable(addr));

    a_r5_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && br_taken && trace_en) |=> vld[0]);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> $stable(addr));
endmodule

// File: tb/branch_trace_queue_test.sv
`timescale 1ns/100ps
module branch_trace_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        br_taken = 1'b0;
    logic [31:0] br_src_addr = '0;
    logic        rd_stb = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference queue, built from the requirements.
    bit          mv [8];
    bit          mk [8];
    logic [27:0] ma [8];
    bit          pen;

    always #5 clk = ~clk;

    branch_trace_queue uut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .br_taken(br_taken),
        .br_src_addr(br_src_addr), .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // Vector layout: {br, en, rd, idx[2:0], addr[31:0]}
    localparam logic [37:0] VEC [12] = '{
        {1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_0000},
        {1'b1, 1'b1, 1'b0, 3'd0, 32'hA000_0010},
        {1'b1, 1'b1, 1'b0, 3'd0, 32'h1234_5678},
        {1'b1, 1'b1, 1'b0, 3'd0, 32'hFFFF_FFFC},
        {1'b0, 1'b1, 1'b1, 3'd0, 32'h0000_0000},
        {1'b1, 1'b1, 1'b1, 3'd2, 32'hDEAD_BEE0},
        {1'b0, 1'b1, 1'b1, 3'd3, 32'h0000_0000},
        {1'b1, 1'b0, 1'b0, 3'd0, 32'h5555_5554},
        {1'b0, 1'b0, 1'b1, 3'd1, 32'h0000_0000},
        {1'b1, 1'b1, 1'b0, 3'd0, 32'h0BAD_F00C},
        {1'b1, 1'b1, 1'b0, 3'd0, 32'h1111_1110},
        {1'b1, 1'b1, 1'b1, 3'd0, 32'h2222_2220}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input logic [31:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (mask %h)", tag, act, exp, mask);
        end
    endtask

    // One stimulus cycle. The reference queue is advanced at the same edge as the design.
    task automatic step(input bit br, input bit en, input bit rd, input logic [2:0] idx,
                        input logic [31:0] a);
        bit rise;
        bit sh;
        @(negedge clk);
        br_taken = br; trace_en = en; rd_stb = rd; rd_idx = idx; br_src_addr = a;
        @(posedge clk);
        rise = en && !pen;
        sh   = br && en;
        if (sh) begin
            for (int i = 7; i > 0; i--) begin
                mv[i] = mv[i-1] && !rise; ma[i] = ma[i-1]; mk[i] = mk[i-1];
            end
            mv[0] = 1'b1; ma[0] = a[27:0]; mk[0] = 1'b1;
        end else begin
            if (rise) for (int i = 0; i < 8; i++) mv[i] = 1'b0;
            if (rd) mv[idx] = 1'b0;
        end
        pen = en;
        #1;
        br_taken = 1'b0; rd_stb = 1'b0;
    endtask

    // Sweep every entry through the read port. The strobes stay idle, so no state changes.
    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            check(tag, rd_data, {mv[i], 3'b000, ma[i]},
                  mk[i] ? 32'hFFFF_FFFF : 32'hF000_0000);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; trace_en = 1'b0; br_taken = 1'b0; rd_stb = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; mk[i] = 1'b0; end
        pen = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_all("R8 reset flags");

        // Table-driven run through the main behaviour.
        for (int v = 0; v < 12; v++) begin
            step(VEC[v][37], VEC[v][36], VEC[v][35], VEC[v][34:32], VEC[v][31:0]);
            check_all("R1 table");
        end

        // R1: ten captures push the oldest records out of the last entry.
        for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b0, 3'd0, 32'h0000_1000 + 32'(k * 4));
        check_all("R1 discard");
        rd_idx = 3'd7; #1;
        check("R1 last entry", rd_data, 32'h8000_1008, 32'hFFFF_FFFF);

        // R2 and R3: explicit word for an all-ones source address.
        step(1'b1, 1'b1, 1'b0, 3'd0, 32'hFFFF_FFFF);
        rd_idx = 3'd0; #1;
        check("R2 R3 head word", rd_data, 32'h8FFF_FFFF, 32'hFFFF_FFFF);
        rd_idx = 3'd1; #1;
        check("R3 reserved bits", rd_data & 32'h7000_0000, 32'h0, 32'hFFFF_FFFF);

        // R4: clear entry 5 only, and no entry moves.
        step(1'b0, 1'b1, 1'b1, 3'd5, 32'h0);
        check_all("R4 read clear");

        // R5: a capture and a read of the head in the same cycle.
        step(1'b1, 1'b1, 1'b1, 3'd0, 32'h0000_ABC0);
        check_all("R5 collision");

        // R7: the enable is low, so these branches are ignored.
        step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
        step(1'b1, 1'b0, 1'b0, 3'd0, 32'h7777_7770);
        step(1'b1, 1'b0, 1'b0, 3'd0, 32'h6666_6660);
        check_all("R7 disabled hold");

        // R6: an enable rise without a capture clears every flag.
        step(1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
        check_all("R6 wipe");
        rd_idx = 3'd0; #1;
        check("R6 head flag", rd_data, 32'h0, 32'h8000_0000);

        // R8: reset in the middle of a run.
        step(1'b1, 1'b1, 1'b0, 3'd0, 32'h0000_0044);
        do_reset();
        check_all("R8 mid-run reset");
        step(1'b1, 1'b1, 1'b0, 3'd0, 32'h0000_0088);
        check_all("R8 R6 first cycle after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule